// File: doc/BRIEF.md
# Flash Status Poll Completion Checker

This block runs on the host side of a flash device and decides when an embedded program or erase operation has finished. A single-cycle `start` pulse supplies the target address and the byte the location should hold when the operation is done. For a program this is the data being written. For an erase it is FFh, and the address may be any location inside the sector being erased. The block then reads the location again and again through a request/valid read port and examines two status bits of each returned byte.

Bit 7 of the returned byte is compared with bit 7 of the expected byte, and a match means the operation is complete. Bit 5 is the device's error indication. If bit 5 is set while bit 7 still disagrees, the block reads once more, because bit 7 can flip in the same cycle as the error bit. Only a second mismatch is reported as a failure. An optional final read compares the whole byte. A poll limit acts as a watchdog and reports a timeout. The results are a one-cycle `done` pulse plus `pass`, `fail` and `timeout` levels, which hold until the next accepted start.

Top module: `flash_poll_checker`

## Requirements
- R1: While a read is outstanding, `rd_req` stays high and `rd_addr` stays equal to the captured target address. A read completes in each cycle where `rd_req` and `rd_valid` are both high, and the block waits as many cycles as it takes for `rd_valid` to arrive.
- R2: In a poll read, if `rd_data[7]` equals bit 7 of the expected byte, the operation is complete. With verify disabled, `done` pulses in the cycle after that read, together with `pass`=1 and `fail`=0.
- R3: In a poll read, if `rd_data[7]` differs from bit 7 of the expected byte and `rd_data[5]`=0, another poll read follows.
- R4: In a poll read, if `rd_data[7]` differs and `rd_data[5]`=1, exactly one more read is made. If bit 7 of that read matches, the result is pass (or goes on to verify when verify is enabled).
- R5: If that extra read after an error still has a mismatching bit 7, the result is `fail`=1 with `timeout`=0.
- R6: An erase is checked by giving FFh as the expected byte. Polls returning bit 7 = 0 with bit 5 = 0 keep polling, and a poll returning bit 7 = 1 completes it.
- R7: When `verify_en` was high at start, a completed poll is followed by one more read. The result is pass only if all 8 bits of that read equal the expected byte, and fail (with `timeout`=0) otherwise.
- R8: After MAX_POLLS consecutive poll reads with a mismatching bit 7 and bit 5 = 0, the block ends with `fail`=1 and `timeout`=1. A match on poll number MAX_POLLS still gives pass.
- R9: `busy` is high from the cycle after an accepted start until `done`. `done` lasts exactly one cycle. `pass`, `fail` and `timeout` are cleared by a start and hold their values until the next start. `pass` and `fail` are never high together.
- R10: A `start` pulse that arrives while `busy` is high is ignored: the address, the expected byte and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a completion check (accepted only when idle) |
| start_addr | input | AW | Location to poll |
| start_data | input | 8 | Expected byte (FFh for erase) |
| verify_en | input | 1 | Do a final full-byte compare |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 8 | Returned status/data byte |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed correctly |
| fail | output | 1 | Operation failed or timed out |
| timeout | output | 1 | Poll limit reached |

## Verification
The hardest case to reach is the error path: bit 5 must rise while bit 7 still disagrees, and the outcome then depends on the very next read. A read-response queue lets the bench script each byte the device returns, so it can present the error byte followed by either a corrected or a still-wrong bit 7. The watchdog boundary comes from the same queue: the bench builds the limit in with a small MAX_POLLS and sends exactly that many non-completing bytes, or one fewer followed by a match. A gap mode that withholds `rd_valid` on alternate cycles checks that the request and address stay stable while the block waits.

// File: rtl/flash_poll_checker.sv
module flash_poll_checker #(
  parameter int AW        = 16,
  parameter int MAX_POLLS = 1024,
  localparam int CW       = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    start_data,
  input  logic          verify_en,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout
);

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_RECHECK, S_VERIFY} state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic [7:0]    exp_q;
  logic          ver_q;
  logic [CW-1:0] cnt_q;

  wire hit   = rd_req && rd_valid;
  wire b7_ok = rd_data[7] == exp_q[7];

  assign rd_req  = state != S_IDLE;
  assign busy    = state != S_IDLE;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      exp_q   <= '0;
      ver_q   <= 1'b0;
      cnt_q   <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          addr_q  <= start_addr;
          exp_q   <= start_data;
          ver_q   <= verify_en;
          cnt_q   <= '0;
          pass    <= 1'b0;
          fail    <= 1'b0;
          timeout <= 1'b0;
          state   <= S_POLL;
        end
        S_POLL: if (hit) begin
          if (b7_ok) begin
            if (ver_q) state <= S_VERIFY;
            else begin
              state <= S_IDLE; done <= 1'b1; pass <= 1'b1;
            end
          end else if (rd_data[5]) begin
            state <= S_RECHECK;
          end else if (cnt_q == CW'(MAX_POLLS - 1)) begin
            state <= S_IDLE; done <= 1'b1; fail <= 1'b1; timeout <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RECHECK: if (hit) begin
          if (b7_ok && ver_q) state <= S_VERIFY;
          else begin
            state <= S_IDLE; done <= 1'b1;
            pass  <= b7_ok;  fail <= !b7_ok;
          end
        end
        S_VERIFY: if (hit) begin
          state <= S_IDLE; done <= 1'b1;
          pass  <= rd_data == exp_q;
          fail  <= rd_data != exp_q;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_pass_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  a_r8_timeout_is_fail: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(rd_addr));
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(pass) && $stable(fail) && $stable(timeout));

endmodule

// File: tb/flash_poll_checker_bench.sv
module flash_poll_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MAXP = 8;

  logic clk = 0, rst_n = 0, start = 0, verify_en = 0, rd_valid = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] start_data = '0, rd_data = '0;
  logic rd_req, busy, done, pass, fail, timeout;
  logic [AW-1:0] rd_addr;

  flash_poll_checker #(.AW(AW), .MAX_POLLS(MAXP)) u_flash_poll_checker (
    .clk, .rst_n, .start, .start_addr, .start_data, .verify_en,
    .rd_req, .rd_addr, .rd_valid, .rd_data,
    .busy, .done, .pass, .fail, .timeout);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic p; logic f; logic t; int reads; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] resp_q[$];
  int checks = 0, failures = 0, nreads = 0, ops_done = 0;
  logic [AW-1:0] exp_addr = '0;
  bit slow = 0, gap = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // responder: one scripted byte per accepted read
  initial forever begin
    @(negedge clk);
    gap = !gap;
    if (rd_req && resp_q.size() > 0 && !(slow && gap)) begin
      rd_valid = 1;
      rd_data  = resp_q.pop_front();
      nreads++;
      chk(rd_addr == exp_addr, "R1 read address", rd_addr, exp_addr);
    end else begin
      rd_valid = 0;
    end
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (done) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(pass == e.p, {e.tag, " pass"}, pass, e.p);
      chk(fail == e.f, {e.tag, " fail"}, fail, e.f);
      chk(timeout == e.t, {e.tag, " timeout"}, timeout, e.t);
      chk(nreads == e.reads, {e.tag, " read count"}, nreads, e.reads);
      ops_done++;
    end
  end

  task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input bit ver,
                        input logic [7:0] rs[], input bit p, input bit t, input string tag,
                        input bit inject = 0);
    exp_t e;
    int target;
    @(negedge clk);
    foreach (rs[i]) resp_q.push_back(rs[i]);
    e.p = p; e.f = !p; e.t = t; e.reads = rs.size(); e.tag = tag;
    exp_q.push_back(e);
    target = ops_done + 1;
    exp_addr = a; nreads = 0;
    start_addr = a; start_data = d; verify_en = ver; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R9 busy after start", busy, 1);
    if (inject) begin
      start_addr = a ^ 16'h0F0F; start_data = ~d; verify_en = !ver; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (ops_done < target) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done == 0 && busy == 0, "R9 done single pulse", done, 0);
    chk(pass == p && fail == !p, "R9 result held", pass, p);
    chk(resp_q.size() == 0, {tag, " responses consumed"}, resp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rd_req == 0, "reset idle", busy, 0);
    chk(pass == 0 && fail == 0 && timeout == 0, "reset results", pass, 0);
    rst_n = 1;
    run_op(16'h1234, 8'h5A, 0, '{8'h00}, 1, 0, "R2 immediate match");
    run_op(16'h2000, 8'hA5, 0, '{8'h05, 8'h05, 8'hA5}, 1, 0, "R3 keep polling");
    run_op(16'h2001, 8'h80, 0, '{8'h20, 8'hA0}, 1, 0, "R4 error then match");
    run_op(16'h2002, 8'h80, 0, '{8'h20, 8'h20}, 0, 0, "R5 error then mismatch");
    run_op(16'h4321, 8'hFF, 0, '{8'h00, 8'h00, 8'hFF}, 1, 0, "R6 erase");
    run_op(16'h4322, 8'hFF, 1, '{8'h40, 8'hFF, 8'hFF}, 1, 0, "R6 R7 erase verify");
    run_op(16'h3000, 8'h3C, 1, '{8'h3C, 8'h3D}, 0, 0, "R7 verify mismatch");
    run_op(16'h3001, 8'h3C, 1, '{8'h3C, 8'h3C}, 1, 0, "R7 verify match");
    run_op(16'h3002, 8'h80, 1, '{8'h20, 8'h80, 8'h81}, 0, 0, "R4 R7 recheck then verify");
    run_op(16'h5000, 8'h80, 0, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
           0, 1, "R8 timeout");
    run_op(16'h5001, 8'h80, 0, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80},
           1, 0, "R8 match at limit");
    slow = 1;
    run_op(16'h6000, 8'hA5, 0, '{8'h05, 8'h25, 8'hA5}, 1, 0, "R1 slow responder");
    slow = 0;
    run_op(16'h7000, 8'hA5, 0, '{8'h05, 8'h05, 8'hA5}, 1, 0, "R10 start while busy", 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule